// File: doc/BRIEF.md
# Sync-Length Decoding Serial Receiver

This block takes serial words off a receive data line that is timed by a receive bit clock and a receive frame sync. It runs on a faster system clock. It synchronises the three serial lines into that domain and finds the falling edges of the bit clock. Data and frame sync are sampled only on those edges. The number of falling edges during which frame sync stays high sets the length of the incoming word. The same count selects the decode algorithm the downstream decoder must apply to that word. Because the length is measured again on every frame, the algorithm can change from one frame to the next without any register write.

Valid lengths are 2, 3, 4 and 8 bits. They select 16, 24 and 32 kbps ADPCM and 64 kbps PCM. A frame sync that is high on exactly one falling edge is a short sync. In that case the following four falling edges carry a 4-bit word. When the PCM mode input is high, the first falling edge with frame sync high starts an 8-bit capture. The capture runs to its end whatever frame sync does afterwards.

When a frame completes, the word, its length, its algorithm code and a short-sync flag are loaded into output registers together. In the same system cycle the block raises a one-cycle interrupt and sets a pending flag. The pending flag stays set until it is acknowledged. A frame whose length is not valid raises a one-cycle frame-error pulse instead.

Top module: `fslen_rx`

## Requirements
- R1: During reset, rx_word, rx_len, rx_alg, rx_short, irq, irq_pend and frame_err are all zero.
- R2: With pcm_mode low, the receiver counts the falling bit-clock edges at which rx_fsync is high. The rx_sdata bits sampled on those edges form the word, first bit most significant, right-aligned in rx_word. The upper bits are zero and rx_len equals the count. The first falling edge with rx_fsync low ends the frame, and its data bit is discarded.
- R3: rx_alg encodes the algorithm from the length: 2 gives 0 (16 kbps), 3 gives 1 (24 kbps), 4 gives 2 (32 kbps) and 8 gives 3 (64 kbps PCM).
- R4: A frame sync that is high on exactly one falling edge is a short sync. The bits on the next four falling edges form a 4-bit word, with rx_len = 4, rx_alg = 2 and rx_short = 1. The short flag is 0 for every other frame.
- R5: With pcm_mode high, the first falling edge with rx_fsync high and the seven edges after it supply 8 bits whatever rx_fsync does. rx_len is 8 and rx_alg is 3.
- R6: irq is high for exactly one system cycle per completed frame. The output registers take their new values in that same cycle.
- R7: irq_pend is set together with irq and stays set until irq_ack is sampled high. A completion in the same cycle as the acknowledge keeps it set.
- R8: A frame with an invalid length (1 with short sync disabled, 5, 6, 7, or more than 8) raises frame_err for one cycle. It gives no irq and leaves the output registers unchanged.
- R9: The length, and with it the algorithm, is decided anew for every frame. Consecutive frames of different lengths are each reported with their own length.
- R10: The output registers do not change in any cycle in which irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bclk | input | 1 | Receive bit clock, asynchronous to clk |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| pcm_mode | input | 1 | Forces fixed 8-bit capture per frame |
| irq_ack | input | 1 | Clears the pending flag |
| rx_word | output | 8 | Last captured word, right-aligned |
| rx_len | output | 4 | Bit count of the last word |
| rx_alg | output | 2 | Decode algorithm code of the last word |
| rx_short | output | 1 | Last word arrived under short sync |
| irq | output | 1 | One-cycle frame-complete pulse |
| irq_pend | output | 1 | Frame complete, not yet acknowledged |
| frame_err | output | 1 | One-cycle invalid-length pulse |

## Verification
Faults in the edge counter or the state register can show up in two ways at the ports. A miscounted length gives a wrong rx_len and rx_alg, or turns a good frame into a frame_err pulse. A state stuck in capture swallows the next frame, so its irq never appears. The reference model predicts each frame's outputs from the stimulus and compares every port on every system cycle. A wrong or missing update is therefore caught within the few cycles of synchroniser latency after the closing bit-clock edge. A spurious update is caught in the cycle it occurs.

// File: rtl/fslen_pkg.sv
package fslen_pkg;

   typedef enum logic [1:0] {
      ALG_ADPCM16 = 2'd0,
      ALG_ADPCM24 = 2'd1,
      ALG_ADPCM32 = 2'd2,
      ALG_PCM64   = 2'd3
   } alg_e;

   typedef enum logic [1:0] {
      CAP_IDLE,
      CAP_LONG,
      CAP_SHORT,
      CAP_PCM
   } cap_st_e;

   localparam int unsigned SHORT_BITS = 4;

   function automatic logic len_ok(input int unsigned len, input int unsigned pcm_len);
      return (len == 2) || (len == 3) || (len == 4) || (len == pcm_len);
   endfunction

   function automatic alg_e len_to_alg(input int unsigned len);
      alg_e a;
      case (len)
         2:       a = ALG_ADPCM16;
         3:       a = ALG_ADPCM24;
         4:       a = ALG_ADPCM32;
         default: a = ALG_PCM64;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/fslen_sync.sv
module fslen_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fslen_capture.sv
module fslen_capture
   import fslen_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter bit SHORT_EN = 1'b1,
   localparam int LEN_W   = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_s,
   input  logic              fsync_s,
   input  logic              data_s,
   input  logic              pcm_mode,
   output logic              done,
   output logic [WORD_W-1:0] done_word,
   output logic [LEN_W-1:0]  done_len,
   output logic              done_short,
   output logic              err
);

   localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
   localparam logic [LEN_W-1:0] CNT_SAT  = LEN_W'(WORD_W + 1);
   localparam logic [LEN_W-1:0] SHORT_LN = LEN_W'(SHORT_BITS);
   localparam logic [LEN_W-1:0] PCM_LN   = LEN_W'(WORD_W);

   cap_st_e           state;
   logic [LEN_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg;
   logic              bclk_prev;
   logic              fall;
   logic [WORD_W-1:0] shifted;
   logic [WORD_W-1:0] fresh;
   logic              short_hit;

   assign fall    = bclk_prev & ~bclk_s;
   assign shifted = {shreg[WORD_W-2:0], data_s};
   assign fresh   = {{(WORD_W-1){1'b0}}, data_s};

   if (SHORT_EN) begin : g_short_on
      assign short_hit = (cnt == ONE);
   end else begin : g_short_off
      assign short_hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= CAP_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         bclk_prev  <= 1'b0;
         done       <= 1'b0;
         err        <= 1'b0;
         done_word  <= '0;
         done_len   <= '0;
         done_short <= 1'b0;
      end else begin
         bclk_prev <= bclk_s;
         done      <= 1'b0;
         err       <= 1'b0;
         if (fall) begin
            unique case (state)
               CAP_IDLE: begin
                  if (fsync_s) begin
                     shreg <= fresh;
                     cnt   <= ONE;
                     state <= pcm_mode ? CAP_PCM : CAP_LONG;
                  end
               end
               CAP_LONG: begin
                  if (fsync_s) begin
                     shreg <= shifted;
                     if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                  end else if (short_hit) begin
                     shreg <= fresh;
                     cnt   <= ONE;
                     state <= CAP_SHORT;
                  end else begin
                     state <= CAP_IDLE;
                     if (len_ok(int'(cnt), WORD_W)) begin
                        done       <= 1'b1;
                        done_word  <= shreg;
                        done_len   <= cnt;
                        done_short <= 1'b0;
                     end else begin
                        err <= 1'b1;
                     end
                  end
               end
               CAP_SHORT: begin
                  shreg <= shifted;
                  cnt   <= cnt + 1'b1;
                  if (cnt == SHORT_LN - 1'b1) begin
                     state      <= CAP_IDLE;
                     done       <= 1'b1;
                     done_word  <= shifted;
                     done_len   <= SHORT_LN;
                     done_short <= 1'b1;
                  end
               end
               CAP_PCM: begin
                  shreg <= shifted;
                  cnt   <= cnt + 1'b1;
                  if (cnt == PCM_LN - 1'b1) begin
                     state      <= CAP_IDLE;
                     done       <= 1'b1;
                     done_word  <= shifted;
                     done_len   <= PCM_LN;
                     done_short <= 1'b0;
                  end
               end
            endcase
         end
      end
   end

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_SAT);

   assert_short_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_short) |-> (done_len == SHORT_LN));

   assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/fslen_outreg.sv
module fslen_outreg
   import fslen_pkg::*;
#(
   parameter int WORD_W  = 8,
   localparam int LEN_W  = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [WORD_W-1:0] done_word,
   input  logic [LEN_W-1:0]  done_len,
   input  logic              done_short,
   input  logic              err,
   input  logic              irq_ack,
   output logic [WORD_W-1:0] rx_word,
   output logic [LEN_W-1:0]  rx_len,
   output logic [1:0]        rx_alg,
   output logic              rx_short,
   output logic              irq,
   output logic              irq_pend,
   output logic              frame_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word   <= '0;
         rx_len    <= '0;
         rx_alg    <= '0;
         rx_short  <= 1'b0;
         irq       <= 1'b0;
         irq_pend  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         irq       <= done;
         frame_err <= err;
         if (done) begin
            rx_word  <= done_word;
            rx_len   <= done_len;
            rx_alg   <= len_to_alg(int'(done_len));
            rx_short <= done_short;
         end
         if (done)         irq_pend <= 1'b1;
         else if (irq_ack) irq_pend <= 1'b0;
      end
   end

   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !irq_ack) |=> irq_pend);

   assert_len_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> len_ok(int'(rx_len), WORD_W));

   assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> ($stable(rx_word) && $stable(rx_len) && $stable(rx_short)));

   assert_err_noirq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !irq);

endmodule

// File: rtl/fslen_rx.sv
module fslen_rx
   import fslen_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SHORT_EN    = 1'b1,
   localparam int LEN_W      = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bclk,
   input  logic              rx_fsync,
   input  logic              rx_sdata,
   input  logic              pcm_mode,
   input  logic              irq_ack,
   output logic [WORD_W-1:0] rx_word,
   output logic [LEN_W-1:0]  rx_len,
   output logic [1:0]        rx_alg,
   output logic              rx_short,
   output logic              irq,
   output logic              irq_pend,
   output logic              frame_err
);

   if (WORD_W < 5) begin : g_bad_width
      $error("fslen_rx: WORD_W must exceed the ADPCM lengths");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fslen_rx: SYNC_STAGES must be at least 2");
   end

   logic [2:0]        sync_q;
   logic              done;
   logic [WORD_W-1:0] done_word;
   logic [LEN_W-1:0]  done_len;
   logic              done_short;
   logic              err;

   fslen_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rx_bclk, rx_fsync, rx_sdata}),
      .q     (sync_q)
   );

   fslen_capture #(.WORD_W(WORD_W), .SHORT_EN(SHORT_EN)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_s     (sync_q[2]),
      .fsync_s    (sync_q[1]),
      .data_s     (sync_q[0]),
      .pcm_mode   (pcm_mode),
      .done       (done),
      .done_word  (done_word),
      .done_len   (done_len),
      .done_short (done_short),
      .err        (err)
   );

   fslen_outreg #(.WORD_W(WORD_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .done_word  (done_word),
      .done_len   (done_len),
      .done_short (done_short),
      .err        (err),
      .irq_ack    (irq_ack),
      .rx_word    (rx_word),
      .rx_len     (rx_len),
      .rx_alg     (rx_alg),
      .rx_short   (rx_short),
      .irq        (irq),
      .irq_pend   (irq_pend),
      .frame_err  (frame_err)
   );

endmodule

// File: tb/test_fslen_rx.sv
`timescale 1ns/1ps
module test_fslen_rx;

   localparam int HALF = 4;
   localparam int WD   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, fs = 1'b0, sd = 1'b0, pcm = 1'b0, ack = 1'b0;
   logic [7:0] rx_word;
   logic [3:0] rx_len;
   logic [1:0] rx_alg;
   logic rx_short, irq, irq_pend, frame_err;

   always #2.5 clk = ~clk;

   fslen_rx i_fslen_rx (
      .clk(clk), .rst_n(rst_n), .rx_bclk(bclk), .rx_fsync(fs), .rx_sdata(sd),
      .pcm_mode(pcm), .irq_ack(ack), .rx_word(rx_word), .rx_len(rx_len),
      .rx_alg(rx_alg), .rx_short(rx_short), .irq(irq), .irq_pend(irq_pend),
      .frame_err(frame_err)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] q_word[$];
   int         q_len[$];
   logic       q_short[$];
   int err_exp = 0, err_seen = 0;
   logic [7:0] cur_word = '0;
   int cur_len = 0;
   logic cur_short = 1'b0;
   logic exp_pend = 1'b0;
   logic prev_irq = 1'b0;
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_alg(input int len);
      case (len)
         2: return 0;
         3: return 1;
         4: return 2;
         default: return 3;
      endcase
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // reference comparison on every clock
   initial forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
         chk(rx_word == 0 && rx_len == 0 && rx_alg == 0 && !rx_short &&
             !irq && !irq_pend && !frame_err, "R1", "reset state",
             {rx_word, rx_len, rx_alg, rx_short, irq, irq_pend, frame_err}, 0);
      end else begin
         if (frame_err) err_seen++;
         if (irq) begin
            chk(!prev_irq, "R6", "irq width", 2, 1);
            if (q_word.size() == 0) begin
               chk(0, "R8", "unexpected irq", 1, 0);
            end else begin
               cur_word = q_word.pop_front();
               cur_len = q_len.pop_front();
               cur_short = q_short.pop_front();
            end
            exp_pend = 1'b1;
         end else if (ack) begin
            exp_pend = 1'b0;
         end
         chk(rx_word == cur_word, "R2", "rx_word", rx_word, cur_word);
         chk(rx_len == cur_len, "R9", "rx_len", rx_len, cur_len);
         chk(rx_alg == exp_alg(cur_len) || cur_len == 0, "R3", "rx_alg", rx_alg, exp_alg(cur_len));
         chk(rx_short == cur_short, "R4", "rx_short", rx_short, cur_short);
         chk(irq_pend == exp_pend, "R7", "irq_pend", irq_pend, exp_pend);
         prev_irq = irq;
      end
   end

   task automatic bit_cycle(input logic f, input logic d);
      @(negedge clk);
      bclk = 1'b1; fs = f; sd = d;
      repeat (HALF) @(negedge clk);
      bclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) bit_cycle(1'b0, 1'b0);
   endtask

   task automatic send_long(input int len, input logic [15:0] w);
      for (int i = 0; i < len; i++) bit_cycle(1'b1, w[len-1-i]);
      if (len == 2 || len == 3 || len == 4 || len == 8) begin
         q_word.push_back(w[7:0] & 8'((1 << len) - 1));
         q_len.push_back(len);
         q_short.push_back(1'b0);
      end else begin
         err_exp++;
      end
      bit_cycle(1'b0, 1'b1);
      idle(2);
   endtask

   task automatic send_short(input logic [3:0] w);
      bit_cycle(1'b1, 1'b1);
      for (int i = 0; i < 4; i++) bit_cycle(1'b0, w[3-i]);
      q_word.push_back({4'h0, w});
      q_len.push_back(4);
      q_short.push_back(1'b1);
      idle(2);
   endtask

   task automatic send_pcm(input logic [7:0] w, input int fs_len);
      for (int i = 0; i < 8; i++) bit_cycle(i < fs_len, w[7-i]);
      q_word.push_back(w);
      q_len.push_back(8);
      q_short.push_back(1'b0);
      idle(2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      send_long(2, 16'h0002);          // R2 R3 16 kbps
      send_long(3, 16'h0003);          // R3 24 kbps
      send_long(4, 16'h000D);          // R3 32 kbps
      send_long(8, 16'h00A5);          // R2 R3 PCM
      send_short(4'h9);                // R4
      send_long(5, 16'h0015);          // R8 invalid length
      chk(err_seen == err_exp, "R8", "frame_err count", err_seen, err_exp);
      send_long(10, 16'h02F3);         // R8 over-long
      chk(err_seen == err_exp, "R8", "frame_err count", err_seen, err_exp);
      pcm = 1'b1;
      send_pcm(8'h3C, 1);              // R5 short pulse, full word
      send_pcm(8'hC3, 8);              // R5 held pulse
      pcm = 1'b0;
      send_long(2, 16'h0001);          // R9 frame-by-frame change
      send_long(8, 16'h005A);
      send_short(4'h6);
      send_long(3, 16'h0006);
      idle(3);
      chk(irq_pend == 1'b1, "R7", "pending before ack", irq_pend, 1);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      @(negedge clk);
      chk(irq_pend == 1'b0, "R7", "pending after ack", irq_pend, 0);
      chk(q_word.size() == 0, "R6", "frames left unreported", q_word.size(), 0);
      chk(err_seen == err_exp, "R8", "frame_err total", err_seen, err_exp);
      done_flag = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done_flag) begin
         chk(0, "R6", "watchdog expired", 1, 0);
         summary();
         $finish;
      end
   end

endmodule